// File: doc/BRIEF.md
# Video Line and Frame Timing Sequencer

This block generates the horizontal and vertical timing skeleton for a serial display link transmitter running in video mode. The horizontal intervals are counted in lane byte clock cycles. They are sync width, back porch and the full line length, plus an active pixel span taken from the packet size value. The front porch is whatever part of the line those intervals leave over. The vertical intervals are counted in lines. A frame runs sync lines first, then back porch lines, then active lines, then front porch lines.

On every cycle the block reports which horizontal and vertical region it is in. It also gives a line-start strobe and a frame-start strobe, and a sync-end strobe that depends on the chosen sync reporting style. Finally it gives an active-pixel window and a flag that says whether the link may drop to low power in the current blanking cycle. Configuration is captured into shadow registers when a frame begins, so a frame never mixes two timings. Lowering the enable input stops the sequence. Raising it again restarts the frame at its first sync line.

Top module: `vid_timing_seq`

## Requirements
- R1: While reset is held, and from the edge after `enable` is sampled low, all strobes, `activePix` and `lpAllowed` are 0, and both region outputs read 0.
- R2: A line lasts `cfgHline` cycles, with a value of 0 treated as 1. Within a line, `hRegion` reads 0 (sync) for the first `cfgHsa` cycles, then 1 (back porch) for `cfgHbp` cycles, then 2 (active) for `cfgPixels` cycles, then 3 (front porch) for the rest of the line. A region that does not fit is cut short at the line end, and the front porch is then zero cycles long.
- R3: A frame lasts `cfgVsa+cfgVbp+cfgVact+cfgVfp` lines, with 0 treated as 1. `vRegion` reads 0 (sync), 1 (back porch), 2 (active) and 3 (front porch), in that order, for those line counts.
- R4: `lineStart` pulses on the first cycle of every line. `frameStart` pulses on the first cycle of line 0 of each frame.
- R5: With `cfgMode` 0 (sync pulses), `syncEnd` pulses in the cycle at line offset `cfgHsa`. With `cfgMode` 1 (sync events), 2 (burst) or 3, `syncEnd` stays 0.
- R6: `activePix` is 1 exactly when both region outputs read 2.
- R7: `lpAllowed` is 0 in every horizontal sync cycle and every active-pixel cycle. In all other cycles it is set by `cfgLpMask`. Bit 0 covers vertical sync lines, bit 1 covers vertical back porch lines and bit 2 covers vertical front porch lines. In active lines, bit 3 must be set together with bit 4 for the horizontal back porch, or together with bit 5 for the horizontal front porch.
- R8: All configuration inputs, including mode and mask, are sampled when the block starts and at the edge that ends the last cycle of a frame. Changes at any other time have no effect until the next frame.
- R9: When `enable` rises, the block begins on the next cycle at line 0, offset 0, with `frameStart` high. This holds again after any stop in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the sequence; low stops it and clears position |
| cfgHsa | input | HW | Horizontal sync width in cycles |
| cfgHbp | input | HW | Horizontal back porch in cycles |
| cfgHline | input | HW | Full line length in cycles |
| cfgPixels | input | PW | Active span in cycles (packet size) |
| cfgVsa | input | VW | Vertical sync lines |
| cfgVbp | input | VW | Vertical back porch lines |
| cfgVact | input | VW | Active lines |
| cfgVfp | input | VW | Vertical front porch lines |
| cfgMode | input | 2 | 0 sync pulses, 1 sync events, 2 burst |
| cfgLpMask | input | 6 | Per-region low-power permission |
| hRegion | output | 2 | Current horizontal region |
| vRegion | output | 2 | Current vertical region |
| lineStart | output | 1 | First cycle of a line |
| frameStart | output | 1 | First cycle of a frame |
| syncEnd | output | 1 | End of horizontal sync (pulse mode only) |
| activePix | output | 1 | Active pixel window |
| lpAllowed | output | 1 | Low power permitted this cycle |

## Verification
The properties take for granted that `enable` and the configuration inputs are synchronous to `clk`. They also assume that only the shadow copies are ever compared with the counters, so they make no demand that configuration be held steady. For that reason the stimulus is free to change line length, active line count and mode in the middle of a frame, and it does so. All inputs are driven on the falling edge. The stimulus also covers a zero line length and a frame with zero lines, because the counter-bound property treats zero as one and must hold in that case too.

// File: rtl/vts_pkg.sv
package vts_pkg;
  typedef enum logic [1:0] {
    RG_SYNC  = 2'd0,
    RG_BACK  = 2'd1,
    RG_ACT   = 2'd2,
    RG_FRONT = 2'd3
  } regionT;

  typedef struct packed {
    logic run;
    logic lineStart;
    logic frameStart;
  } tickT;
endpackage

// File: rtl/vts_ctrl.sv
module vts_ctrl
  import vts_pkg::*;
#(
  parameter int HW = 14,
  parameter int VW = 12,
  parameter int PW = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [HW-1:0]   cfgHsa,
  input  logic [HW-1:0]   cfgHbp,
  input  logic [HW-1:0]   cfgHline,
  input  logic [PW-1:0]   cfgPixels,
  input  logic [VW-1:0]   cfgVsa,
  input  logic [VW-1:0]   cfgVbp,
  input  logic [VW-1:0]   cfgVact,
  input  logic [VW-1:0]   cfgVfp,
  input  logic [1:0]      cfgMode,
  input  logic [5:0]      cfgLpMask,
  output tickT            tick,
  output logic [HW-1:0]   hCnt,
  output logic [VW+1:0]   vCnt,
  output logic [HW-1:0]   sHsa,
  output logic [HW-1:0]   sHbp,
  output logic [PW-1:0]   sPixels,
  output logic [VW-1:0]   sVsa,
  output logic [VW-1:0]   sVbp,
  output logic [VW-1:0]   sVact,
  output logic [1:0]      sMode,
  output logic [5:0]      sLpMask
);
  localparam int VT = VW + 2;

  logic          run;
  logic [HW-1:0] sHline;
  logic [VW-1:0] sVfp;
  logic [VT-1:0] vTotal;
  logic          lineEnd, frameEnd, loadNow;

  assign vTotal   = VT'(sVsa) + VT'(sVbp) + VT'(sVact) + VT'(sVfp);
  assign lineEnd  = ({1'b0, hCnt} + (HW+1)'(1)) >= {1'b0, sHline};
  assign frameEnd = lineEnd && ((vCnt + VT'(1)) >= vTotal);
  assign loadNow  = !run || (enable && frameEnd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run  <= 1'b0;
      hCnt <= '0;
      vCnt <= '0;
    end else begin
      run <= enable;
      if (!enable) begin
        hCnt <= '0;
        vCnt <= '0;
      end else if (run) begin
        if (frameEnd) begin
          hCnt <= '0;
          vCnt <= '0;
        end else if (lineEnd) begin
          hCnt <= '0;
          vCnt <= vCnt + VT'(1);
        end else begin
          hCnt <= hCnt + HW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sHsa <= '0; sHbp <= '0; sHline <= '0; sPixels <= '0;
      sVsa <= '0; sVbp <= '0; sVact <= '0; sVfp <= '0;
      sMode <= '0; sLpMask <= '0;
    end else if (loadNow) begin
      sHsa <= cfgHsa; sHbp <= cfgHbp; sHline <= cfgHline; sPixels <= cfgPixels;
      sVsa <= cfgVsa; sVbp <= cfgVbp; sVact <= cfgVact; sVfp <= cfgVfp;
      sMode <= cfgMode; sLpMask <= cfgLpMask;
    end
  end

  assign tick.run        = run;
  assign tick.lineStart  = run && (hCnt == '0);
  assign tick.frameStart = run && (hCnt == '0) && (vCnt == '0);

  // R2: the horizontal position never reaches the programmed line length
  a_r2_hcnt_in_line: assert property (@(posedge clk) disable iff (!rstN)
    run |-> (hCnt < sHline) || (hCnt == '0));

  // R9: a restart always begins at the frame origin
  a_r9_restart_origin: assert property (@(posedge clk) disable iff (!rstN)
    $rose(run) |-> (hCnt == '0) && (vCnt == '0));

  // R8: shadows move only at a frame boundary or while stopped
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rstN)
    (run && enable && !frameEnd) |=> $stable(sHline) && $stable(sVact)
      && $stable(sMode) && $stable(sLpMask) && $stable(sPixels));
endmodule

// File: rtl/vts_datapath.sv
module vts_datapath
  import vts_pkg::*;
#(
  parameter int HW = 14,
  parameter int VW = 12,
  parameter int PW = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  tickT            tick,
  input  logic [HW-1:0]   hCnt,
  input  logic [VW+1:0]   vCnt,
  input  logic [HW-1:0]   sHsa,
  input  logic [HW-1:0]   sHbp,
  input  logic [PW-1:0]   sPixels,
  input  logic [VW-1:0]   sVsa,
  input  logic [VW-1:0]   sVbp,
  input  logic [VW-1:0]   sVact,
  input  logic [1:0]      sMode,
  input  logic [5:0]      sLpMask,
  output logic [1:0]      hRegion,
  output logic [1:0]      vRegion,
  output logic            lineStart,
  output logic            frameStart,
  output logic            syncEnd,
  output logic            activePix,
  output logic            lpAllowed
);
  localparam int HS = ((HW > PW) ? HW : PW) + 2;
  localparam int VT = VW + 2;

  logic [HS-1:0] hEdge1, hEdge2, hEdge3, hPos;
  logic [VT-1:0] vEdge1, vEdge2, vEdge3;
  regionT        hReg, vReg;
  logic          lpRaw;

  assign hPos   = HS'(hCnt);
  assign hEdge1 = HS'(sHsa);
  assign hEdge2 = hEdge1 + HS'(sHbp);
  assign hEdge3 = hEdge2 + HS'(sPixels);
  assign vEdge1 = VT'(sVsa);
  assign vEdge2 = vEdge1 + VT'(sVbp);
  assign vEdge3 = vEdge2 + VT'(sVact);

  always_comb begin
    if      (hPos < hEdge1) hReg = RG_SYNC;
    else if (hPos < hEdge2) hReg = RG_BACK;
    else if (hPos < hEdge3) hReg = RG_ACT;
    else                    hReg = RG_FRONT;
    if      (vCnt < vEdge1) vReg = RG_SYNC;
    else if (vCnt < vEdge2) vReg = RG_BACK;
    else if (vCnt < vEdge3) vReg = RG_ACT;
    else                    vReg = RG_FRONT;
  end

  always_comb begin
    unique case (vReg)
      RG_SYNC:  lpRaw = sLpMask[0];
      RG_BACK:  lpRaw = sLpMask[1];
      RG_FRONT: lpRaw = sLpMask[2];
      default: begin
        if      (hReg == RG_BACK)  lpRaw = sLpMask[3] && sLpMask[4];
        else if (hReg == RG_FRONT) lpRaw = sLpMask[3] && sLpMask[5];
        else                       lpRaw = 1'b0;
      end
    endcase
    if (hReg == RG_SYNC) lpRaw = 1'b0;
  end

  assign hRegion    = tick.run ? hReg : RG_SYNC;
  assign vRegion    = tick.run ? vReg : RG_SYNC;
  assign lineStart  = tick.lineStart;
  assign frameStart = tick.frameStart;
  assign syncEnd    = tick.run && (sMode == 2'd0) && (hCnt == sHsa);
  assign activePix  = tick.run && (hReg == RG_ACT) && (vReg == RG_ACT);
  assign lpAllowed  = tick.run && lpRaw;

  // R5: the end strobe exists only in the sync-pulse style
  a_r5_end_pulse_mode: assert property (@(posedge clk) disable iff (!rstN)
    syncEnd |-> (sMode == 2'd0));

  // R7: never low power while pixels flow
  a_r7_lp_not_pixels: assert property (@(posedge clk) disable iff (!rstN)
    !(lpAllowed && activePix));

  // R7: never low power during horizontal sync
  a_r7_lp_not_sync: assert property (@(posedge clk) disable iff (!rstN)
    lpAllowed |-> (hRegion != 2'd0));

  // R4: a frame start is always also a line start
  a_r4_frame_is_line: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> lineStart && (vCnt == '0));
endmodule

// File: rtl/vid_timing_seq.sv
module vid_timing_seq
  import vts_pkg::*;
#(
  parameter int HW = 14,
  parameter int VW = 12,
  parameter int PW = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            enable,
  input  logic [HW-1:0]   cfgHsa,
  input  logic [HW-1:0]   cfgHbp,
  input  logic [HW-1:0]   cfgHline,
  input  logic [PW-1:0]   cfgPixels,
  input  logic [VW-1:0]   cfgVsa,
  input  logic [VW-1:0]   cfgVbp,
  input  logic [VW-1:0]   cfgVact,
  input  logic [VW-1:0]   cfgVfp,
  input  logic [1:0]      cfgMode,
  input  logic [5:0]      cfgLpMask,
  output logic [1:0]      hRegion,
  output logic [1:0]      vRegion,
  output logic            lineStart,
  output logic            frameStart,
  output logic            syncEnd,
  output logic            activePix,
  output logic            lpAllowed
);
  tickT          tick;
  logic [HW-1:0] hCnt, sHsa, sHbp;
  logic [VW+1:0] vCnt;
  logic [PW-1:0] sPixels;
  logic [VW-1:0] sVsa, sVbp, sVact;
  logic [1:0]    sMode;
  logic [5:0]    sLpMask;

  vts_ctrl #(.HW(HW), .VW(VW), .PW(PW)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable),
    .cfgHsa(cfgHsa), .cfgHbp(cfgHbp), .cfgHline(cfgHline), .cfgPixels(cfgPixels),
    .cfgVsa(cfgVsa), .cfgVbp(cfgVbp), .cfgVact(cfgVact), .cfgVfp(cfgVfp),
    .cfgMode(cfgMode), .cfgLpMask(cfgLpMask),
    .tick(tick), .hCnt(hCnt), .vCnt(vCnt),
    .sHsa(sHsa), .sHbp(sHbp), .sPixels(sPixels),
    .sVsa(sVsa), .sVbp(sVbp), .sVact(sVact),
    .sMode(sMode), .sLpMask(sLpMask)
  );

  vts_datapath #(.HW(HW), .VW(VW), .PW(PW)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .hCnt(hCnt), .vCnt(vCnt),
    .sHsa(sHsa), .sHbp(sHbp), .sPixels(sPixels),
    .sVsa(sVsa), .sVbp(sVbp), .sVact(sVact),
    .sMode(sMode), .sLpMask(sLpMask),
    .hRegion(hRegion), .vRegion(vRegion), .lineStart(lineStart),
    .frameStart(frameStart), .syncEnd(syncEnd), .activePix(activePix),
    .lpAllowed(lpAllowed)
  );
endmodule

// File: tb/vid_timing_seq_bench.sv
module vid_timing_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN, enable;
  logic [13:0] cfgHsa, cfgHbp, cfgHline, cfgPixels;
  logic [11:0] cfgVsa, cfgVbp, cfgVact, cfgVfp;
  logic [1:0]  cfgMode;
  logic [5:0]  cfgLpMask;
  logic [1:0]  hRegion, vRegion;
  logic        lineStart, frameStart, syncEnd, activePix, lpAllowed;

  vid_timing_seq u_vid_timing_seq (.*);

  int nChecks = 0, nFail = 0;
  int mHsa, mHbp, mHline, mPix, mVsa, mVbp, mVact, mVfp, mMode, mLp;
  int k;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d k=%0d", tag, act, exp, k);
    end
  endtask

  task automatic latchModel();
    mHsa = cfgHsa; mHbp = cfgHbp; mHline = cfgHline; mPix = cfgPixels;
    mVsa = cfgVsa; mVbp = cfgVbp; mVact = cfgVact; mVfp = cfgVfp;
    mMode = cfgMode; mLp = cfgLpMask;
  endtask

  function automatic int hlen(); return (mHline < 1) ? 1 : mHline; endfunction
  function automatic int vlen();
    int t = mVsa + mVbp + mVact + mVfp;
    return (t < 1) ? 1 : t;
  endfunction

  task automatic checkIdle(string tag);
    chk({tag, " R1 idle outputs"},
        {hRegion, vRegion, lineStart, frameStart, syncEnd, activePix, lpAllowed}, 0);
  endtask

  task automatic checkCycle(string note);
    int h = k % hlen();
    int v = k / hlen();
    int eh, ev, elp;
    eh = (h < mHsa) ? 0 : (h < mHsa + mHbp) ? 1 : (h < mHsa + mHbp + mPix) ? 2 : 3;
    ev = (v < mVsa) ? 0 : (v < mVsa + mVbp) ? 1 : (v < mVsa + mVbp + mVact) ? 2 : 3;
    if (ev == 0) elp = mLp & 1;
    else if (ev == 1) elp = (mLp >> 1) & 1;
    else if (ev == 3) elp = (mLp >> 2) & 1;
    else if (eh == 1) elp = ((mLp >> 3) & (mLp >> 4)) & 1;
    else if (eh == 3) elp = ((mLp >> 3) & (mLp >> 5)) & 1;
    else elp = 0;
    if (eh == 0) elp = 0;
    chk({"R2 hRegion", note}, hRegion, eh);
    chk({"R3 vRegion", note}, vRegion, ev);
    chk({"R4 lineStart", note}, lineStart, (h == 0) ? 1 : 0);
    chk({"R4 frameStart", note}, frameStart, (k == 0) ? 1 : 0);
    chk({"R5 syncEnd", note}, syncEnd, (mMode == 0 && h == mHsa) ? 1 : 0);
    chk({"R6 activePix", note}, activePix, (eh == 2 && ev == 2) ? 1 : 0);
    chk({"R7 lpAllowed", note}, lpAllowed, elp);
  endtask

  task automatic step();
    if (k + 1 >= hlen() * vlen()) begin
      k = 0;
      latchModel();
    end else k++;
    @(negedge clk);
  endtask

  task automatic runCycles(int n, string note);
    for (int i = 0; i < n; i++) begin
      checkCycle(note);
      step();
    end
  endtask

  task automatic startRun();
    enable = 1'b1;
    latchModel();
    k = 0;
    @(negedge clk);
  endtask

  task automatic stopRun(string tag);
    enable = 1'b0;
    @(negedge clk);
    checkIdle(tag);
  endtask

  task automatic baseCfg();
    cfgHsa = 2; cfgHbp = 3; cfgHline = 12; cfgPixels = 4;
    cfgVsa = 1; cfgVbp = 1; cfgVact = 3; cfgVfp = 2;
    cfgMode = 0; cfgLpMask = 6'h3f;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; k = 0;
    baseCfg();
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    // R9 start, base timing, pulse mode, two frames
    startRun();
    runCycles(168, " base");

    // R5 every sync style
    for (int m = 1; m < 4; m++) begin
      stopRun("R1 stop");
      cfgMode = m[1:0];
      cfgLpMask = 6'(m * 21);
      startRun();
      runCycles(84, " mode");
    end

    // R2 front porch clipped to zero, and exactly zero
    stopRun("R1 stop");
    cfgMode = 0; cfgPixels = 8;
    startRun();
    runCycles(84, " clip");
    stopRun("R1 stop");
    cfgPixels = 7;
    startRun();
    runCycles(84, " nofp");

    // near-exhaustive sweep of small horizontal and vertical splits
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          stopRun("R1 stop");
          cfgHsa = 14'(a); cfgHbp = 14'(b); cfgPixels = 14'(3 + c);
          cfgHline = 14'(6 + a + c);
          cfgVsa = 12'(c); cfgVbp = 12'(b); cfgVact = 12'(1 + a); cfgVfp = 12'((a + c) % 2);
          cfgMode = 2'((a + b) % 3);
          cfgLpMask = 6'((a * 13 + b * 7 + c * 29) % 64);
          startRun();
          runCycles(hlen() * vlen() + 2, " sweep");
        end

    // R8 mid-frame changes wait for the next frame
    stopRun("R1 stop");
    baseCfg();
    startRun();
    runCycles(30, " R8 before");
    cfgHline = 9; cfgVact = 2; cfgMode = 1; cfgLpMask = 6'h15;
    latchModel();
    mHline = 12; mVact = 3; mMode = 0; mLp = 6'h3f;
    runCycles(54 + 126, " R8 after");

    // R9 stop mid-frame, restart from origin
    runCycles(17, " R9 pre");
    stopRun("R9 stop");
    startRun();
    runCycles(70, " R9 restart");

    // degenerate: zero line length, zero lines
    stopRun("R1 stop");
    cfgHline = 0; cfgVsa = 0; cfgVbp = 0; cfgVact = 0; cfgVfp = 0;
    startRun();
    runCycles(6, " R2 R3 degenerate");
    stopRun("R1 final");

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule